// File: doc/BRIEF.md
# Fused Loop-Closing Branch Unit

This block resolves a loop-closing instruction in one step. It takes the current loop index and adds a signed step to it, or subtracts one in the count-down forms. It then tests the exit condition for the selected mode and chooses the next program counter. If the loop continues, the next PC is the loop-top address. If the loop ends, the next PC is the fall-through address. The updated index is always written back, whether or not the branch is taken.

Five modes are provided:

- Signed index-below-limit.
- Operand inequality.
- Index-below-limit combined with a nonzero flag operand.
- Decrement and stop at zero.
- Decrement and stop at minus one.

The add, the compare and the branch decision form one combinational path. An optional output register stage follows that path and is enabled by default. A pipeline uses the block where its branch unit would otherwise need three separate instructions: an add, a compare and a conditional branch.

Top module: `loop_branch_unit`

## Requirements
- R1: With mode code 0, the new index is idx + step, wrapping modulo 2^DW. The branch is taken exactly when the new index, read as a signed number, is below the signed limit.
- R2: With mode code 1, the branch is taken exactly when operand A differs from operand B. The index still becomes idx + step.
- R3: With mode code 2, the new index is idx + step. The branch is taken only when the signed new index is below the signed limit and the flag operand is nonzero.
- R4: The step is a two's-complement value, so a negative step makes the index count downward in modes 0 to 2.
- R5: With mode code 3, the new index is idx - 1 and the step input is ignored. The branch is taken exactly when the new index is nonzero.
- R6: With mode code 4, the new index is idx - 1 and the step input is ignored. The branch is taken unless the new index is all ones (minus one).
- R7: The next PC equals the loop-top target when the branch is taken. Otherwise it equals the fall-through address.
- R8: Mode codes 5, 6 and 7 never take the branch. They leave the index unchanged and select the fall-through address.
- R9: With the default registered output, results appear on the outputs at the first rising clock edge after the inputs are applied. A low rst_n sampled at a rising edge clears all three outputs to zero.
- R10: The updated index reaches idx_o whether or not the branch is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset of the output stage |
| mode_i | input | 3 | Loop mode code (0 to 4 valid, 5 to 7 fall through) |
| idx_i | input | DW | Current loop index |
| step_i | input | DW | Signed index step for modes 0 to 2 |
| limit_i | input | DW | Signed limit for modes 0 and 2 |
| opa_i | input | DW | First comparison operand for mode 1 |
| opb_i | input | DW | Second comparison operand for mode 1 |
| flag_i | input | DW | Flag operand for mode 2, nonzero means continue |
| target_i | input | AW | Loop-top address |
| fallthru_i | input | AW | Address following the loop instruction |
| idx_o | output | DW | Updated index |
| taken_o | output | 1 | High when the branch back to the loop top is taken |
| next_pc_o | output | AW | Selected next program counter |

## Verification
All three results share the same latency in the default build: each is due at the first rising edge after its inputs. The bench therefore changes inputs on the falling edge and reads outputs 1 ns after the next rising edge. Before that edge, a separate directed check confirms that the outputs still hold the previous result. The bound checker compares each output against the inputs captured one cycle earlier. It is only armed once a full clock cycle without reset has passed, so the register contents left by reset are never compared against stale inputs.

// File: rtl/lbu_pkg.sv
// Package: shared mode codes for the fused loop-closing branch unit.
// Assumes: mode codes 0..4 are defined, anything above is treated as unused.
package lbu_pkg;

    typedef enum logic [2:0] {
        LM_BELOW      = 3'd0,
        LM_DIFFER     = 3'd1,
        LM_BELOW_FLAG = 3'd2,
        LM_DOWN_ZERO  = 3'd3,
        LM_DOWN_NEG1  = 3'd4
    } loop_mode_e;

    localparam logic [2:0] LM_LAST_VALID = 3'd4;

    // Reports whether a raw mode code names one of the defined loop forms.
    function automatic logic mode_known(input logic [2:0] code);
        return code <= LM_LAST_VALID;
    endfunction

endpackage

// File: rtl/lbu_index_step.sv
// Module: computes the written-back loop index for every mode.
// Assumes: two's-complement wrap on overflow; count-down modes ignore step.
module lbu_index_step
    import lbu_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [2:0]    mode_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] step_i,
    output logic [DW-1:0] idx_next_o
);

    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] sum_step;
    logic [DW-1:0] sum_down;

    // Both candidate updates are formed in parallel.
    always_comb begin
        sum_step = idx_i + step_i;
        sum_down = idx_i - ONE;
    end

    // Pick the update that belongs to the selected mode.
    always_comb begin
        case (mode_i)
            LM_BELOW, LM_DIFFER, LM_BELOW_FLAG: idx_next_o = sum_step;
            LM_DOWN_ZERO, LM_DOWN_NEG1:         idx_next_o = sum_down;
            default:                            idx_next_o = idx_i;
        endcase
    end

endmodule

// File: rtl/lbu_cond_eval.sv
// Module: evaluates the continue condition from the updated index.
// Assumes: limit tests are signed and use the post-step index.
module lbu_cond_eval
    import lbu_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [2:0]    mode_i,
    input  logic [DW-1:0] idx_next_i,
    input  logic [DW-1:0] limit_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [DW-1:0] flag_i,
    output logic          cont_o
);

    logic below;
    logic differ;
    logic flag_set;
    logic nonzero;
    logic not_neg1;

    // Raw compare terms, all computed side by side.
    always_comb begin
        below    = $signed(idx_next_i) < $signed(limit_i);
        differ   = opa_i != opb_i;
        flag_set = |flag_i;
        nonzero  = |idx_next_i;
        not_neg1 = ~(&idx_next_i);
    end

    // Select the term that ends the loop in the chosen mode.
    always_comb begin
        if (!mode_known(mode_i)) begin
            cont_o = 1'b0;
        end else begin
            case (mode_i)
                LM_BELOW:      cont_o = below;
                LM_DIFFER:     cont_o = differ;
                LM_BELOW_FLAG: cont_o = below & flag_set;
                LM_DOWN_ZERO:  cont_o = nonzero;
                LM_DOWN_NEG1:  cont_o = not_neg1;
                default:       cont_o = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/lbu_out_stage.sv
// Module: optional output register for index, decision and next PC.
// Assumes: REG_OUT=1 adds one cycle; REG_OUT=0 is a straight wire.
module lbu_out_stage #(
    parameter int DW      = 64,
    parameter int AW      = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] idx_d,
    input  logic          taken_d,
    input  logic [AW-1:0] pc_d,
    output logic [DW-1:0] idx_q,
    output logic          taken_q,
    output logic [AW-1:0] pc_q
);

    generate
        if (REG_OUT) begin : g_reg
            // Capture the results every cycle, cleared by synchronous reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idx_q   <= '0;
                    taken_q <= 1'b0;
                    pc_q    <= '0;
                end else begin
                    idx_q   <= idx_d;
                    taken_q <= taken_d;
                    pc_q    <= pc_d;
                end
            end
        end else begin : g_wire
            // Pass the combinational results through unchanged.
            always_comb begin
                idx_q   = idx_d;
                taken_q = taken_d;
                pc_q    = pc_d;
            end
        end
    endgenerate

endmodule

// File: rtl/loop_branch_unit.sv
// Module: top of the fused add / compare / branch loop-closing unit.
// Assumes: one instruction per cycle; the caller writes idx_o back.
module loop_branch_unit
    import lbu_pkg::*;
#(
    parameter int DW      = 64,
    parameter int AW      = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] step_i,
    input  logic [DW-1:0] limit_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [DW-1:0] flag_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] fallthru_i,
    output logic [DW-1:0] idx_o,
    output logic          taken_o,
    output logic [AW-1:0] next_pc_o
);

    logic [DW-1:0] idx_next;
    logic          cont;
    logic [AW-1:0] pc_sel;

    lbu_index_step #(.DW(DW)) u_step (
        .mode_i     (mode_i),
        .idx_i      (idx_i),
        .step_i     (step_i),
        .idx_next_o (idx_next)
    );

    lbu_cond_eval #(.DW(DW)) u_cond (
        .mode_i     (mode_i),
        .idx_next_i (idx_next),
        .limit_i    (limit_i),
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .flag_i     (flag_i),
        .cont_o     (cont)
    );

    // Steer the next PC from the continue decision.
    always_comb begin
        pc_sel = cont ? target_i : fallthru_i;
    end

    lbu_out_stage #(.DW(DW), .AW(AW), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_d   (idx_next),
        .taken_d (cont),
        .pc_d    (pc_sel),
        .idx_q   (idx_o),
        .taken_q (taken_o),
        .pc_q    (next_pc_o)
    );

endmodule

// File: rtl/lbu_checker.sv
// Module: temporal checks on the registered build of the loop branch unit.
// Assumes: armed only after one full cycle out of reset; inactive when REG_OUT=0.
module lbu_checker #(
    parameter int DW      = 64,
    parameter int AW      = 64,
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    mode_i,
    input logic [DW-1:0] idx_i,
    input logic [DW-1:0] step_i,
    input logic [DW-1:0] limit_i,
    input logic [DW-1:0] opa_i,
    input logic [DW-1:0] opb_i,
    input logic [DW-1:0] flag_i,
    input logic [AW-1:0] target_i,
    input logic [AW-1:0] fallthru_i,
    input logic [DW-1:0] idx_o,
    input logic          taken_o,
    input logic [AW-1:0] next_pc_o
);

    logic past_live = 1'b0;

    // Arm the checks once the previous cycle was out of reset.
    always_ff @(posedge clk) begin
        past_live <= rst_n;
    end

    generate
        if (REG_OUT) begin : g_chk
            assert_pc_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && taken_o |-> next_pc_o == $past(target_i));
            assert_pc_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && !taken_o |-> next_pc_o == $past(fallthru_i));
            assert_unused_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && $past(mode_i) > 3'd4 |-> !taken_o && idx_o == $past(idx_i));
            assert_limit_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && $past(mode_i) == 3'd0 |->
                    taken_o == ($signed(idx_o) < $signed($past(limit_i))));
            assert_differ_R2: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && $past(mode_i) == 3'd1 |->
                    taken_o == ($past(opa_i) != $past(opb_i)) &&
                    idx_o == $past(idx_i) + $past(step_i));
            assert_flag_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && $past(mode_i) == 3'd2 && $past(flag_i) == '0 |-> !taken_o);
            assert_down_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && $past(mode_i) == 3'd3 |->
                    taken_o == ($past(idx_i) != {{(DW-1){1'b0}}, 1'b1}));
            assert_down_neg1_R6: assert property (@(posedge clk) disable iff (!rst_n)
                past_live && $past(mode_i) == 3'd4 |->
                    taken_o == ($past(idx_i) != '0));
        end
    endgenerate

endmodule

bind loop_branch_unit lbu_checker #(.DW(DW), .AW(AW), .REG_OUT(REG_OUT)) u_lbu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .idx_i      (idx_i),
    .step_i     (step_i),
    .limit_i    (limit_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .flag_i     (flag_i),
    .target_i   (target_i),
    .fallthru_i (fallthru_i),
    .idx_o      (idx_o),
    .taken_o    (taken_o),
    .next_pc_o  (next_pc_o)
);

// File: tb/tb_loop_branch_unit.sv
`timescale 1ns/1ps
module tb_loop_branch_unit;

    localparam int DW = 64;
    localparam int AW = 64;
    localparam int NV = 17;
    localparam logic [63:0] NEG1 = 64'hFFFF_FFFF_FFFF_FFFF;

    // Vector table: mode, idx, step, limit, opa, opb, flag, expected idx, expected taken
    localparam logic [2:0]  V_MODE [NV] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2,
                                            3'd2, 3'd3, 3'd3, 3'd3, 3'd4, 3'd4, 3'd5, 3'd7};
    localparam logic [63:0] V_IDX  [NV] = '{64'd5, 64'd9, 64'd0, 64'd10, 64'h7FFF_FFFF_FFFF_FFFF,
                                            64'd3, 64'd3, 64'd1, 64'd1, 64'd4, 64'd5, 64'd1, 64'd0,
                                            64'd0, 64'd1, 64'd42, 64'd9};
    localparam logic [63:0] V_STEP [NV] = '{64'd1, 64'd1, 64'd1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd1,
                                            64'd4, 64'd4, 64'd1, 64'd1, 64'd1, 64'd7, 64'd7, 64'd7,
                                            64'd7, 64'd7, 64'd3, 64'd3};
    localparam logic [63:0] V_LIM  [NV] = '{64'd10, 64'd10, NEG1, 64'd9, 64'd0, 64'd0, 64'd0,
                                            64'd5, 64'd5, 64'd5, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
                                            64'd100, 64'd100};
    localparam logic [63:0] V_OPA  [NV] = '{64'd1, 64'd1, 64'd1, 64'd1, 64'd1, 64'd7, 64'd7,
                                            64'd1, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1, 64'd1,
                                            64'd1, 64'd1};
    localparam logic [63:0] V_OPB  [NV] = '{64'd2, 64'd2, 64'd2, 64'd2, 64'd2, 64'd8, 64'd7,
                                            64'd2, 64'd2, 64'd2, 64'd2, 64'd2, 64'd2, 64'd2, 64'd2,
                                            64'd2, 64'd2};
    localparam logic [63:0] V_FLAG [NV] = '{64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
                                            64'd1, 64'd0, 64'd3, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
                                            64'd1, 64'd1};
    localparam logic [63:0] V_EIDX [NV] = '{64'd6, 64'd10, 64'd1, 64'd8, 64'h8000_0000_0000_0000,
                                            64'd7, 64'd7, 64'd2, 64'd2, 64'd5, 64'd4, 64'd0, NEG1,
                                            NEG1, 64'd0, 64'd42, 64'd9};
    localparam logic        V_ETKN [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
                                            1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam string       V_REQ  [NV] = '{"R1", "R1", "R1", "R4", "R1", "R2", "R2", "R3", "R3",
                                            "R3", "R5", "R5", "R5", "R6", "R6", "R8", "R8"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_i = '0;
    logic [DW-1:0] idx_i = '0, step_i = '0, limit_i = '0, opa_i = '0, opb_i = '0, flag_i = '0;
    logic [AW-1:0] target_i = '0, fallthru_i = '0;
    logic [DW-1:0] idx_o;
    logic          taken_o;
    logic [AW-1:0] next_pc_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    loop_branch_unit #(.DW(DW), .AW(AW), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .idx_i(idx_i), .step_i(step_i),
        .limit_i(limit_i), .opa_i(opa_i), .opb_i(opb_i), .flag_i(flag_i),
        .target_i(target_i), .fallthru_i(fallthru_i),
        .idx_o(idx_o), .taken_o(taken_o), .next_pc_o(next_pc_o)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_vec(input int i);
        @(negedge clk);
        mode_i     = V_MODE[i];
        idx_i      = V_IDX[i];
        step_i     = V_STEP[i];
        limit_i    = V_LIM[i];
        opa_i      = V_OPA[i];
        opb_i      = V_OPB[i];
        flag_i     = V_FLAG[i];
        target_i   = 64'h1000 + 64'(i) * 64'h10;
        fallthru_i = 64'h2000 + 64'(i) * 64'h10;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        // R9: reset state of all outputs
        repeat (3) @(posedge clk);
        #1;
        chk("R9", "reset idx", idx_o, '0);
        chk("R9", "reset taken", 64'(taken_o), 64'd0);
        chk("R9", "reset pc", next_pc_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1..R8, R10 (index written back also on fall-through)
        for (int i = 0; i < NV; i++) begin
            logic [63:0] exp_pc;
            drive_vec(i);
            @(posedge clk);
            #1;
            exp_pc = V_ETKN[i] ? (64'h1000 + 64'(i) * 64'h10) : (64'h2000 + 64'(i) * 64'h10);
            chk(V_REQ[i], $sformatf("vec %0d idx", i), idx_o, V_EIDX[i]);
            chk(V_REQ[i], $sformatf("vec %0d taken", i), 64'(taken_o), 64'(V_ETKN[i]));
            chk("R7", $sformatf("vec %0d pc", i), next_pc_o, exp_pc);
            if (!V_ETKN[i] && V_MODE[i] <= 3'd4)
                chk("R10", $sformatf("vec %0d idx on fall-through", i), idx_o, V_EIDX[i]);
        end

        // R9: latency, outputs hold the previous result until the next rising edge
        drive_vec(0);
        @(posedge clk);
        #1;
        drive_vec(1);
        #1;
        chk("R9", "hold before edge idx", idx_o, 64'd6);
        chk("R9", "hold before edge taken", 64'(taken_o), 64'd1);
        @(posedge clk);
        #1;
        chk("R9", "update after edge idx", idx_o, 64'd10);
        chk("R9", "update after edge taken", 64'(taken_o), 64'd0);

        // R5: step input has no effect in count-down mode
        @(negedge clk);
        mode_i = 3'd3; idx_i = 64'd100; step_i = NEG1;
        @(posedge clk);
        #1;
        chk("R5", "step ignored idx", idx_o, 64'd99);

        // R9: synchronous reset in mid-run with a taken vector on the inputs
        drive_vec(0);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R9", "mid reset idx", idx_o, '0);
        chk("R9", "mid reset taken", 64'(taken_o), 64'd0);
        chk("R9", "mid reset pc", next_pc_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R9", "post reset taken", 64'(taken_o), 64'd1);

        done = 1'b1;
        finish_run();
    end

endmodule